// File: doc/BRIEF.md
# Pong Physics Engine

This block advances the state of a two-paddle ball game. It runs only during a compute phase, which a one-cycle start pulse opens. Between phases the host renders the game and the block holds every output. A compute phase is a fixed number of small ticks. Each tick first moves both paddles from their previous position and velocity and from that player's joystick. It then moves the ball and decides on any bounces.

Positions are unsigned fixed-point numbers with 10 integer bits and 6 fraction bits, so one pixel is 64 units. Velocities are signed 16-bit numbers in the same units. Bounces are found by presenting four obstacles to a single collision evaluator, one per clock: the top wall, the bottom wall, the left paddle and the right paddle. The block accumulates one reflection flag for each axis and applies the flags once, at the end of the tick. When the ball leaves through the left or right edge, the opposing player scores and the ball is served again from the centre of the court.

The start pulse and the done flag are plain control pins and carry no back-pressure. The joysticks are sampled once, on the edge that accepts the start pulse. While a phase is running, the host may change the joystick inputs freely and may pulse start again; the block takes no notice of either.

Top module: `pong_physics`

## Requirements
- R1: After reset, both paddles are at ((COURT_H-PAD_H)/2)*64. The ball is at (COURT_W*32, COURT_H*32) with velocity (VX0, VY0). Both scores are 0 and done is 0.
- R2: When start is high at a clock edge while no phase is running, that edge accepts the start, clears done and captures joy0 and joy1 for the whole phase. The phase runs TICKS ticks of 6 clocks each. done is high after 6*TICKS+1 rising edges, where the edge that accepted start is edge 1.
- R3: Once done is high, it stays high and every state output stays unchanged until the next start. A start pulse during a running phase has no effect on the phase length or on the results.
- R4: On each tick, a paddle's velocity becomes floor((v + j)/2), where j is the captured signed 8-bit joystick value in 1/64-pixel units. Its position then becomes p + v_new.
- R5: If that new position is below 0 or above (COURT_H-PAD_H)*64, the position is clamped to that limit and the paddle's velocity is set to 0.
- R6: On each tick, the ball's next position is the current position plus the velocity. If vy<0 and next y<0, or if vy>0 and next y>=COURT_H*64, then vy is negated and y is left unchanged. Otherwise y takes the next value.
- R7: The left paddle reflects the ball when all of the following hold: vx<0, x>=PAD0_X*64, next x<PAD0_X*64, and y lies within [paddle0_y, paddle0_y+PAD_H*64]. The right paddle reflects the ball when vx>0, x<=PAD1_X*64, next x>PAD1_X*64, and y lies within its span. A reflection negates vx and leaves x unchanged. The paddle positions used are the ones from the same tick.
- R8: In one tick, each axis is reflected at most once, however many obstacles report a hit on it.
- R9: If x is not reflected and next x<0, player 1 scores. If x is not reflected and next x>=COURT_W*64, player 0 scores. In either case the ball moves to the centre, vx is negated and vy is kept.
- R10: Each score counter saturates at 15 and never decreases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Compute-phase start pulse |
| joy0 | input | 8 | Player 0 signed joystick velocity |
| joy1 | input | 8 | Player 1 signed joystick velocity |
| done | output | 1 | Compute phase finished, state stable |
| paddle0_y | output | 16 | Left paddle top position, Q10.6 |
| paddle1_y | output | 16 | Right paddle top position, Q10.6 |
| ball_x | output | 16 | Ball x position, Q10.6 |
| ball_y | output | 16 | Ball y position, Q10.6 |
| ball_vx | output | 16 | Ball x velocity, signed Q10.6 |
| ball_vy | output | 16 | Ball y velocity, signed Q10.6 |
| score0 | output | 4 | Player 0 score |
| score1 | output | 4 | Player 1 score |

## Verification
The bench builds the block with a 64 by 48 court, 12-pixel paddles at columns 4 and 59, 40 ticks per phase and a serve velocity of (150, 37). The court is small and the ball fast, so forty phases cover many wall bounces, paddle returns, misses and points, and they drive at least one score into saturation. Joystick values at both extremes pin the paddles against the clamps. The reduced tick count keeps each phase short enough that the exact 6*TICKS+1 latency can be checked on every phase.

// File: rtl/pong_pkg.sv
package pong_pkg;
  localparam int POS_W = 16;
  localparam int FRAC  = 6;
  localparam int EXT_W = POS_W + 2;
  localparam int NOBJ  = 4;
  localparam int OBJ_W = 2;

  typedef logic [POS_W-1:0]        pos_t;
  typedef logic signed [POS_W-1:0] vel_t;
  typedef logic signed [EXT_W-1:0] ext_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PAD, ST_SCAN, ST_COMMIT} step_e;

  typedef enum logic [OBJ_W-1:0] {OB_TOP, OB_BOTTOM, OB_LEFT, OB_RIGHT} obst_e;

  function automatic ext_t widen_pos(pos_t p);
    return $signed({2'b00, p});
  endfunction

  function automatic ext_t widen_vel(vel_t v);
    return $signed({{2{v[POS_W-1]}}, v});
  endfunction
endpackage

// File: rtl/pong_paddle_step.sv
module pong_paddle_step
  import pong_pkg::*;
#(
  parameter int COURT_H = 240,
  parameter int PAD_H   = 40,
  parameter int JOY_W   = 8
) (
  input  pos_t                   pos_in,
  input  vel_t                   vel_in,
  input  logic signed [JOY_W-1:0] joy,
  output pos_t                   pos_out,
  output vel_t                   vel_out
);
  localparam ext_t TOP_LIMIT = ext_t'((COURT_H - PAD_H) << FRAC);

  ext_t sum, half, moved;

  always_comb begin
    sum   = widen_vel(vel_in) + $signed({{(EXT_W-JOY_W){joy[JOY_W-1]}}, joy});
    half  = sum >>> 1;
    moved = widen_pos(pos_in) + half;
    if (moved[EXT_W-1]) begin
      pos_out = '0;
      vel_out = '0;
    end else if (moved > TOP_LIMIT) begin
      pos_out = TOP_LIMIT[POS_W-1:0];
      vel_out = '0;
    end else begin
      pos_out = moved[POS_W-1:0];
      vel_out = half[POS_W-1:0];
    end
  end
endmodule

// File: rtl/pong_collide.sv
module pong_collide
  import pong_pkg::*;
#(
  parameter int COURT_H = 240,
  parameter int PAD_H   = 40,
  parameter int PAD0_X  = 16,
  parameter int PAD1_X  = 303
) (
  input  obst_e obj,
  input  pos_t  bx,
  input  pos_t  by,
  input  vel_t  vx,
  input  vel_t  vy,
  input  pos_t  pad0,
  input  pos_t  pad1,
  output logic  hit_x,
  output logic  hit_y
);
  localparam ext_t FLOOR_Y = ext_t'(COURT_H << FRAC);
  localparam ext_t LEFT_X  = ext_t'(PAD0_X << FRAC);
  localparam ext_t RIGHT_X = ext_t'(PAD1_X << FRAC);
  localparam ext_t SPAN    = ext_t'(PAD_H << FRAC);

  ext_t nx, ny, cx, cy, top0, top1;
  logic in_span0, in_span1;

  always_comb begin
    cx   = widen_pos(bx);
    cy   = widen_pos(by);
    nx   = cx + widen_vel(vx);
    ny   = cy + widen_vel(vy);
    top0 = widen_pos(pad0);
    top1 = widen_pos(pad1);
    in_span0 = (cy >= top0) && (cy <= top0 + SPAN);
    in_span1 = (cy >= top1) && (cy <= top1 + SPAN);
    hit_x = 1'b0;
    hit_y = 1'b0;
    unique case (obj)
      OB_TOP:    hit_y = vy[POS_W-1] && ny[EXT_W-1];
      OB_BOTTOM: hit_y = !vy[POS_W-1] && (vy != '0) && (ny >= FLOOR_Y);
      OB_LEFT:   hit_x = vx[POS_W-1] && (cx >= LEFT_X) && (nx < LEFT_X) && in_span0;
      OB_RIGHT:  hit_x = !vx[POS_W-1] && (vx != '0) && (cx <= RIGHT_X) && (nx > RIGHT_X) && in_span1;
      default: ;
    endcase
  end
endmodule

// File: rtl/pong_ball_commit.sv
module pong_ball_commit
  import pong_pkg::*;
#(
  parameter int COURT_W = 320,
  parameter int COURT_H = 240,
  parameter int SCORE_W = 4
) (
  input  pos_t               bx,
  input  pos_t               by,
  input  vel_t               vx,
  input  vel_t               vy,
  input  logic               flip_x,
  input  logic               flip_y,
  input  logic [SCORE_W-1:0] s0_in,
  input  logic [SCORE_W-1:0] s1_in,
  output pos_t               bx_out,
  output pos_t               by_out,
  output vel_t               vx_out,
  output vel_t               vy_out,
  output logic [SCORE_W-1:0] s0_out,
  output logic [SCORE_W-1:0] s1_out
);
  localparam ext_t               WALL_X = ext_t'(COURT_W << FRAC);
  localparam pos_t               MID_X  = pos_t'(COURT_W << (FRAC - 1));
  localparam pos_t               MID_Y  = pos_t'(COURT_H << (FRAC - 1));
  localparam logic [SCORE_W-1:0] S_MAX  = '1;
  localparam logic [SCORE_W-1:0] S_ONE  = SCORE_W'(1);

  ext_t nx, ny;
  logic exit_left, exit_right;

  always_comb begin
    nx = widen_pos(bx) + widen_vel(vx);
    ny = widen_pos(by) + widen_vel(vy);
    exit_left  = !flip_x && nx[EXT_W-1];
    exit_right = !flip_x && !nx[EXT_W-1] && (nx >= WALL_X);
    bx_out = flip_x ? bx : nx[POS_W-1:0];
    by_out = flip_y ? by : ny[POS_W-1:0];
    vx_out = flip_x ? -vx : vx;
    vy_out = flip_y ? -vy : vy;
    s0_out = s0_in;
    s1_out = s1_in;
    if (exit_left || exit_right) begin
      bx_out = MID_X;
      by_out = MID_Y;
      vx_out = -vx;
    end
    if (exit_left && (s1_in != S_MAX))  s1_out = s1_in + S_ONE;
    if (exit_right && (s0_in != S_MAX)) s0_out = s0_in + S_ONE;
  end
endmodule

// File: rtl/pong_sequencer.sv
module pong_sequencer
  import pong_pkg::*;
#(
  parameter int TICKS = 255
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output step_e step,
  output obst_e obj,
  output logic  done
);
  localparam int                CNT_W    = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0]  LAST_T   = CNT_W'(TICKS - 1);
  localparam logic [CNT_W-1:0]  T_ONE    = CNT_W'(1);
  localparam logic [OBJ_W-1:0]  LAST_OBJ = OBJ_W'(NOBJ - 1);

  logic [CNT_W-1:0] tick_q;
  logic [OBJ_W-1:0] obj_q;

  assign obj = obst_e'(obj_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step   <= ST_IDLE;
      tick_q <= '0;
      obj_q  <= '0;
      done   <= 1'b0;
    end else begin
      unique case (step)
        ST_IDLE: if (start) begin
          step   <= ST_PAD;
          tick_q <= '0;
          done   <= 1'b0;
        end
        ST_PAD: begin
          step  <= ST_SCAN;
          obj_q <= '0;
        end
        ST_SCAN: begin
          if (obj_q == LAST_OBJ) step <= ST_COMMIT;
          else obj_q <= obj_q + OBJ_W'(1);
        end
        ST_COMMIT: begin
          if (tick_q == LAST_T) begin
            step <= ST_IDLE;
            done <= 1'b1;
          end else begin
            tick_q <= tick_q + T_ONE;
            step   <= ST_PAD;
          end
        end
        default: step <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pong_physics.sv
module pong_physics
  import pong_pkg::*;
#(
  parameter int COURT_W = 320,
  parameter int COURT_H = 240,
  parameter int PAD_H   = 40,
  parameter int PAD0_X  = 16,
  parameter int PAD1_X  = 303,
  parameter int TICKS   = 255,
  parameter int VX0     = 64,
  parameter int VY0     = 32,
  parameter int SCORE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic signed [7:0]  joy0,
  input  logic signed [7:0]  joy1,
  output logic               done,
  output logic [15:0]        paddle0_y,
  output logic [15:0]        paddle1_y,
  output logic [15:0]        ball_x,
  output logic [15:0]        ball_y,
  output logic signed [15:0] ball_vx,
  output logic signed [15:0] ball_vy,
  output logic [SCORE_W-1:0] score0,
  output logic [SCORE_W-1:0] score1
);
  localparam int   JOY_W   = 8;
  localparam int   NPLAYER = 2;
  localparam pos_t PAD_RST = pos_t'(((COURT_H - PAD_H) / 2) << FRAC);
  localparam pos_t MID_X   = pos_t'(COURT_W << (FRAC - 1));
  localparam pos_t MID_Y   = pos_t'(COURT_H << (FRAC - 1));

  step_e step;
  obst_e obj;

  pos_t pad_pos [NPLAYER];
  vel_t pad_vel [NPLAYER];
  pos_t pad_pos_nx [NPLAYER];
  vel_t pad_vel_nx [NPLAYER];
  logic signed [JOY_W-1:0] joy_q [NPLAYER];
  logic signed [JOY_W-1:0] joy_in [NPLAYER];

  pos_t bx_q, by_q;
  vel_t vx_q, vy_q;
  logic flip_x_q, flip_y_q;
  logic hit_x, hit_y;
  logic [SCORE_W-1:0] s0_q, s1_q, s0_nx, s1_nx;
  pos_t bx_nx, by_nx;
  vel_t vx_nx, vy_nx;

  assign joy_in[0] = joy0;
  assign joy_in[1] = joy1;

  pong_sequencer #(.TICKS(TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .step(step), .obj(obj), .done(done)
  );

  for (genvar p = 0; p < NPLAYER; p++) begin : g_player
    pong_paddle_step #(.COURT_H(COURT_H), .PAD_H(PAD_H), .JOY_W(JOY_W)) u_step (
      .pos_in(pad_pos[p]), .vel_in(pad_vel[p]), .joy(joy_q[p]),
      .pos_out(pad_pos_nx[p]), .vel_out(pad_vel_nx[p])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pad_pos[p] <= PAD_RST;
        pad_vel[p] <= '0;
        joy_q[p]   <= '0;
      end else begin
        if (step == ST_IDLE && start) joy_q[p] <= joy_in[p];
        if (step == ST_PAD) begin
          pad_pos[p] <= pad_pos_nx[p];
          pad_vel[p] <= pad_vel_nx[p];
        end
      end
    end
  end

  pong_collide #(
    .COURT_H(COURT_H), .PAD_H(PAD_H), .PAD0_X(PAD0_X), .PAD1_X(PAD1_X)
  ) u_collide (
    .obj(obj), .bx(bx_q), .by(by_q), .vx(vx_q), .vy(vy_q),
    .pad0(pad_pos[0]), .pad1(pad_pos[1]),
    .hit_x(hit_x), .hit_y(hit_y)
  );

  pong_ball_commit #(.COURT_W(COURT_W), .COURT_H(COURT_H), .SCORE_W(SCORE_W)) u_commit (
    .bx(bx_q), .by(by_q), .vx(vx_q), .vy(vy_q),
    .flip_x(flip_x_q), .flip_y(flip_y_q), .s0_in(s0_q), .s1_in(s1_q),
    .bx_out(bx_nx), .by_out(by_nx), .vx_out(vx_nx), .vy_out(vy_nx),
    .s0_out(s0_nx), .s1_out(s1_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bx_q     <= MID_X;
      by_q     <= MID_Y;
      vx_q     <= vel_t'(VX0);
      vy_q     <= vel_t'(VY0);
      flip_x_q <= 1'b0;
      flip_y_q <= 1'b0;
      s0_q     <= '0;
      s1_q     <= '0;
    end else begin
      unique case (step)
        ST_PAD: begin
          flip_x_q <= 1'b0;
          flip_y_q <= 1'b0;
        end
        ST_SCAN: begin
          flip_x_q <= flip_x_q | hit_x;
          flip_y_q <= flip_y_q | hit_y;
        end
        ST_COMMIT: begin
          bx_q <= bx_nx;
          by_q <= by_nx;
          vx_q <= vx_nx;
          vy_q <= vy_nx;
          s0_q <= s0_nx;
          s1_q <= s1_nx;
        end
        default: ;
      endcase
    end
  end

  assign paddle0_y = pad_pos[0];
  assign paddle1_y = pad_pos[1];
  assign ball_x    = bx_q;
  assign ball_y    = by_q;
  assign ball_vx   = vx_q;
  assign ball_vy   = vy_q;
  assign score0    = s0_q;
  assign score1    = s1_q;
endmodule

// File: rtl/pong_physics_chk.sv
module pong_physics_chk #(
  parameter int COURT_W = 320,
  parameter int COURT_H = 240,
  parameter int PAD_H   = 40,
  parameter int SCORE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               done,
  input logic [15:0]        paddle0_y,
  input logic [15:0]        paddle1_y,
  input logic [15:0]        ball_x,
  input logic [15:0]        ball_y,
  input logic [15:0]        ball_vx,
  input logic [15:0]        ball_vy,
  input logic [SCORE_W-1:0] score0,
  input logic [SCORE_W-1:0] score1
);
  localparam logic [15:0]        PAD_MAX = 16'((COURT_H - PAD_H) << 6);
  localparam logic [15:0]        FLOOR_Y = 16'(COURT_H << 6);
  localparam logic [15:0]        MID_X   = 16'(COURT_W << 5);
  localparam logic [15:0]        MID_Y   = 16'(COURT_H << 5);
  localparam logic [SCORE_W-1:0] S_ONE   = SCORE_W'(1);

  // R3
  hold_while_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(ball_x) && $stable(ball_y) && $stable(ball_vx)
      && $stable(ball_vy) && $stable(paddle0_y) && $stable(paddle1_y)
      && $stable(score0) && $stable(score1)));

  // R2
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done);

  // R5
  paddle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paddle0_y <= PAD_MAX) && (paddle1_y <= PAD_MAX));

  // R6
  ball_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ball_y < FLOOR_Y);

  // R10
  score_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (score0 != $past(score0)) |-> (score0 == $past(score0) + S_ONE));

  // R10
  score1_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (score1 != $past(score1)) |-> (score1 == $past(score1) + S_ONE));

  // R9
  serve_centre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((score0 != $past(score0)) || (score1 != $past(score1))) |-> (ball_x == MID_X && ball_y == MID_Y));
endmodule

bind pong_physics pong_physics_chk #(
  .COURT_W(COURT_W), .COURT_H(COURT_H), .PAD_H(PAD_H), .SCORE_W(SCORE_W)
) u_pong_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .paddle0_y(paddle0_y), .paddle1_y(paddle1_y), .ball_x(ball_x), .ball_y(ball_y),
  .ball_vx(ball_vx), .ball_vy(ball_vy), .score0(score0), .score1(score1)
);

// File: tb/test_pong_physics.sv
module test_pong_physics;
  localparam int W = 64, H = 48, PH = 12, P0X = 4, P1X = 59, T = 40, VX0 = 150, VY0 = 37;
  localparam int PHASES = 40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic signed [7:0] joy0 = '0, joy1 = '0;
  logic done;
  logic [15:0] paddle0_y, paddle1_y, ball_x, ball_y;
  logic signed [15:0] ball_vx, ball_vy;
  logic [3:0] score0, score1;

  integer checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  integer mp0, mp1, mv0, mv1, mbx, mby, mvx, mvy, ms0, ms1;

  always #2 clk = ~clk;

  pong_physics #(.COURT_W(W), .COURT_H(H), .PAD_H(PH), .PAD0_X(P0X), .PAD1_X(P1X),
    .TICKS(T), .VX0(VX0), .VY0(VY0), .SCORE_W(4)) i_pong_physics (
    .clk(clk), .rst_n(rst_n), .start(start), .joy0(joy0), .joy1(joy1), .done(done),
    .paddle0_y(paddle0_y), .paddle1_y(paddle1_y), .ball_x(ball_x), .ball_y(ball_y),
    .ball_vx(ball_vx), .ball_vy(ball_vy), .score0(score0), .score1(score1));

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000 && !finished) begin
      fails = fails + 1;
      $display("FAIL R2 watchdog act=%0d exp=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic chk(input string tag, input integer act, input integer exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string when);
    integer vx, vy;
    vx = ball_vx;
    vy = ball_vy;
    chk({"R4 R5 paddle0 ", when}, paddle0_y, mp0);
    chk({"R4 R5 paddle1 ", when}, paddle1_y, mp1);
    chk({"R6 R7 R8 ball_x ", when}, ball_x, mbx);
    chk({"R6 R7 R8 ball_y ", when}, ball_y, mby);
    chk({"R6 R7 R8 ball_vx ", when}, vx, mvx);
    chk({"R6 R7 R8 ball_vy ", when}, vy, mvy);
    chk({"R9 R10 score0 ", when}, score0, ms0);
    chk({"R9 R10 score1 ", when}, score1, ms1);
  endtask

  task automatic paddle_model(inout integer p, inout integer v, input integer j);
    v = (v + j) >>> 1;
    p = p + v;
    if (p < 0) begin p = 0; v = 0; end
    else if (p > (H - PH) * 64) begin p = (H - PH) * 64; v = 0; end
  endtask

  task automatic model_phase(input integer j0, input integer j1);
    for (int t = 0; t < T; t++) begin
      integer nx, ny;
      bit fx, fy;
      paddle_model(mp0, mv0, j0);
      paddle_model(mp1, mv1, j1);
      nx = mbx + mvx;
      ny = mby + mvy;
      fx = 0;
      fy = 0;
      if (mvy < 0 && ny < 0) fy = 1;
      if (mvy > 0 && ny >= H * 64) fy = 1;
      if (mvx < 0 && mbx >= P0X * 64 && nx < P0X * 64 && mby >= mp0 && mby <= mp0 + PH * 64) fx = 1;
      if (mvx > 0 && mbx <= P1X * 64 && nx > P1X * 64 && mby >= mp1 && mby <= mp1 + PH * 64) fx = 1;
      if (fy) mvy = -mvy; else mby = ny;
      if (fx) mvx = -mvx;
      else if (nx < 0 || nx >= W * 64) begin
        if (nx < 0) begin if (ms1 < 15) ms1 = ms1 + 1; end
        else begin if (ms0 < 15) ms0 = ms0 + 1; end
        mbx = W * 32;
        mby = H * 32;
        mvx = -mvx;
      end else mbx = nx;
    end
  endtask

  initial begin
    integer edges;
    mp0 = ((H - PH) / 2) * 64; mp1 = mp0; mv0 = 0; mv1 = 0;
    mbx = W * 32; mby = H * 32; mvx = VX0; mvy = VY0; ms0 = 0; ms1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    compare_all("R1 reset");
    chk("R1 done at reset", done, 0);

    for (int k = 0; k < PHASES; k++) begin
      integer j0, j1;
      j0 = (k < 8) ? -128 : (k < 12) ? 127 : ((k * 53) % 256) - 128;
      j1 = (k < 8) ? 127 : (k < 12) ? -128 : ((k * 91) % 256) - 128;
      joy0 = 8'(j0);
      joy1 = 8'(j1);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      // R2: joysticks captured at start; scramble them for the rest of the phase
      joy0 = 8'(j1 + 7);
      joy1 = 8'(j0 - 3);
      edges = 1;
      while (!done && edges < 10 * T + 10) begin
        // R3: a start pulse mid-phase is ignored
        start = (k == 5 && edges == 50) || (k == 20 && edges == 3);
        @(posedge clk);
        edges = edges + 1;
        @(negedge clk);
      end
      start = 1'b0;
      model_phase(j0, j1);
      chk("R2 phase latency", edges, 6 * T + 1);
      compare_all("R2 end of phase");
      for (int i = 0; i < 2; i++) begin
        joy0 = 8'(i * 40 - 100);
        joy1 = 8'(90 - i * 33);
        @(posedge clk);
        @(negedge clk);
        chk("R3 done held", done, 1);
        compare_all("R3 idle hold");
      end
    end
    // R10: by now the pinned-paddle phases have produced many points
    chk("R10 saturation reached", (ms0 == 15 || ms1 == 15) ? ((score0 == 15 || score1 == 15) ? 1 : 0) : 1, 1);
    summary();
  end
endmodule